// File: doc/BRIEF.md
# Queue Head Transfer Sequencer

This block walks a circular ring of endpoint queue heads in memory. A single request/response memory port carries every access. On each visit it reads five words of the queue head: the horizontal link, the static endpoint word, the current descriptor pointer, the overlay next-descriptor pointer and the overlay token. Its next step depends on the overlay state. It may run one bus transaction through an abstract transaction engine and write the updated token back into the overlay. It may instead load the next transfer descriptor into the overlay, or leave the queue head untouched. It then follows the horizontal link to the next queue head.

Error flags collect in the overlay token for the whole life of a descriptor. They reach the descriptor in memory only when the descriptor retires, either because it completed or because it halted. A descriptor that completes without a halt is replaced on a later visit by the next one in its chain, with no help from software. A halted overlay stays where it is.

Memory words are 32 bits and addresses are word addresses. A queue head occupies words +0..+4 from its base. A descriptor occupies +0 (next pointer) and +1 (token). In any pointer, bit 0 set means terminate. Token layout: bits 30:16 hold the bytes remaining and bits 11:10 hold the error counter. Status sits in bits 7:0 as follows: bit 7 active, bit 6 halted, bit 5 buffer error, bit 4 babble, bit 3 transaction error.

Top module: `qh_sequencer`

## Requirements
- R1: Each visit reads queue-head words base+0, +1, +2, +3, +4 in that order. Each request stays asserted, with a stable address, until it is acknowledged.
- R2: An overlay that is active (bit 7) and not halted (bit 6) gets exactly one transaction per visit. txn_len carries the token's bytes-remaining field and txn_ep carries word +1. The request is held until txn_done, and the memory port and the engine are never used in the same cycle.
- R3: After a transaction, the token is written back to base+4 with the bytes remaining reduced by txn_moved.
- R4: Error flags reported on txn_err are ORed into the status and stay set: bit 0 sets status bit 3, bit 1 sets bit 5, bit 2 sets bit 4. While the descriptor is still active, its token word in memory is not written.
- R5: On retirement, meaning the token's active bit has just been cleared, the final token is written to the current descriptor's word +1 first and then to base+4. A descriptor completes when its bytes remaining reaches 0.
- R6: Babble halts the descriptor (status bit 6 set, bit 7 cleared). A transaction error with a nonzero counter decrements the counter, and the step from 1 to 0 halts. A counter of 0 never halts. A halted overlay gets no transaction and no write.
- R7: An inactive, non-halted overlay whose next pointer is not terminated loads that descriptor. It reads descriptor words +0 and +1, then writes base+2 (new current pointer), base+3 (the descriptor's next pointer) and base+4 (its token).
- R8: An inactive overlay whose next pointer has bit 0 set causes no write and no transaction.
- R9: When sched_en is high the walk starts at head_ptr and then follows each horizontal link. When sched_en is low at the end of a visit, the sequencer goes idle with no further requests.
- R10: During reset, mem_req and txn_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_en | input | 1 | Schedule enable |
| head_ptr | input | AW | First queue head address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| txn_req | output | 1 | Transaction request |
| txn_ep | output | 32 | Endpoint characteristics word |
| txn_len | output | 15 | Bytes remaining in descriptor |
| txn_done | input | 1 | Transaction finished |
| txn_moved | input | 15 | Bytes moved by the transaction |
| txn_err | input | 3 | {babble, buffer error, transaction error} |

## Verification
The assertions assume that mem_ack and txn_done are pulses that answer an open request, and that txn_moved never exceeds txn_len. The assertions also assume that no queue head's base+4 coincides with a descriptor token address. The bench's memory and engine models answer only pending requests, one cycle later. Its engine moves at most the requested length, and queue heads and descriptors are placed in disjoint aligned regions.

// File: rtl/qh_sequencer.sv
module qh_sequencer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched_en,
  input  logic [AW-1:0] head_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          txn_req,
  output logic [31:0]   txn_ep,
  output logic [14:0]   txn_len,
  input  logic          txn_done,
  input  logic [14:0]   txn_moved,
  input  logic [2:0]    txn_err
);
  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_DEC, S_TXN, S_WQTD, S_WTOK, S_F0, S_F1, S_WCUR, S_WNXT, S_NEXT
  } state_t;

  state_t        state;
  logic [2:0]    idx;
  logic [AW-1:0] qh, link, cur, nxt, nn;
  logic [31:0]   ep, tok;
  localparam logic [AW-1:0] MASK = ~AW'(1);

  logic [1:0]  cerr, cerr_n;
  logic [14:0] rem;
  logic        xe, be, bb, hlt, fin;
  logic [31:0] tok_n;

  assign cerr   = tok[11:10];
  assign {bb, be, xe} = txn_err;
  assign cerr_n = (xe && cerr != 2'd0) ? cerr - 2'd1 : cerr;
  assign hlt    = bb | (xe && cerr == 2'd1);
  assign rem    = tok[30:16] - txn_moved;
  assign fin    = (rem == 15'd0);
  assign tok_n  = {1'b0, rem, 4'b0, cerr_n, 2'b0,
                   ~(hlt | fin) & tok[7], tok[6] | hlt, tok[5] | be,
                   tok[4] | bb, tok[3] | xe, tok[2:0]};

  assign txn_req = (state == S_TXN);
  assign txn_ep  = ep;
  assign txn_len = tok[30:16];
  assign mem_req = state inside {S_RD, S_WQTD, S_WTOK, S_F0, S_F1, S_WCUR, S_WNXT};
  assign mem_we  = state inside {S_WQTD, S_WTOK, S_WCUR, S_WNXT};

  always_comb begin
    mem_addr  = qh + AW'(idx);
    mem_wdata = tok;
    case (state)
      S_WQTD: mem_addr = cur + AW'(1);
      S_WTOK: mem_addr = qh + AW'(4);
      S_F0:   mem_addr = nxt & MASK;
      S_F1:   mem_addr = (nxt & MASK) + AW'(1);
      S_WCUR: begin mem_addr = qh + AW'(2); mem_wdata = 32'(cur); end
      S_WNXT: begin mem_addr = qh + AW'(3); mem_wdata = 32'(nxt); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx <= '0; qh <= '0; link <= '0; cur <= '0; nxt <= '0; nn <= '0;
      ep <= '0; tok <= '0;
    end else begin
      case (state)
        S_IDLE: if (sched_en) begin qh <= head_ptr & MASK; idx <= '0; state <= S_RD; end
        S_RD: if (mem_ack) begin
          case (idx)
            3'd0: link <= mem_rdata[AW-1:0];
            3'd1: ep   <= mem_rdata;
            3'd2: cur  <= mem_rdata[AW-1:0] & MASK;
            3'd3: nxt  <= mem_rdata[AW-1:0];
            default: tok <= mem_rdata;
          endcase
          if (idx == 3'd4) state <= S_DEC;
          else idx <= idx + 3'd1;
        end
        S_DEC:
          if (tok[6])      state <= S_NEXT;
          else if (tok[7]) state <= S_TXN;
          else if (nxt[0]) state <= S_NEXT;
          else             state <= S_F0;
        S_TXN: if (txn_done) begin
          tok   <= tok_n;
          state <= tok_n[7] ? S_WTOK : S_WQTD;
        end
        S_WQTD: if (mem_ack) state <= S_WTOK;
        S_WTOK: if (mem_ack) state <= S_NEXT;
        S_F0:   if (mem_ack) begin nn <= mem_rdata[AW-1:0]; state <= S_F1; end
        S_F1:   if (mem_ack) begin
          tok <= mem_rdata; cur <= nxt & MASK; nxt <= nn; state <= S_WCUR;
        end
        S_WCUR: if (mem_ack) state <= S_WNXT;
        S_WNXT: if (mem_ack) state <= S_WTOK;
        S_NEXT: begin
          qh <= link & MASK; idx <= '0;
          state <= sched_en ? S_RD : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_txn_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req && !txn_done |=> txn_req && $stable(txn_len));
  assert_port_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_req && mem_req));
  assert_halt_no_txn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txn_req) |-> tok[7] && !tok[6]);
  assert_retire_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_addr == cur + AW'(1) |-> !tok[7]);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |=> !mem_req && !txn_req);
endmodule

// File: tb/test_qh_sequencer.sv
module test_qh_sequencer;
  logic clk = 0, rst_n = 0, sched_en = 0;
  logic [15:0] head_ptr = 16'h10;
  logic mem_req, mem_we, mem_ack = 0, txn_req, txn_done = 0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0, txn_ep;
  logic [14:0] txn_len, txn_moved = 0;
  logic [2:0]  txn_err = 0;

  qh_sequencer i_qh_sequencer (.*);
  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] mem [256];
  int wr_a, wr_b, writes, txns, nrd, kerr, bb_at, chunk = 4;
  logic [15:0] rdlog [16];

  always_ff @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1;
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata; writes <= writes + 1;
        if (mem_addr == 16'h41) wr_a <= wr_a + 1;
        if (mem_addr == 16'h49) wr_b <= wr_b + 1;
      end else begin
        mem_rdata <= mem[mem_addr[7:0]];
        if (nrd < 16) rdlog[nrd] <= mem_addr;
        nrd <= nrd + 1;
      end
    end else mem_ack <= 0;
    if (txn_req && !txn_done) begin
      txn_done <= 1; txns <= txns + 1;
      if (txns < kerr) begin txn_err <= 3'b001; txn_moved <= 0; end
      else if (txns == bb_at) begin txn_err <= 3'b100; txn_moved <= 0; end
      else begin txn_err <= 0; txn_moved <= (txn_len < 15'(chunk)) ? txn_len : 15'(chunk); end
    end else txn_done <= 0;
  end

  function automatic logic [31:0] pk(int st, int ce, int len);
    return {1'b0, 15'(len), 4'b0, 2'(ce), 2'b0, 8'(st)};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic setup();
    for (int i = 0; i < 256; i++) mem[i] = 0;
    mem[8'h10] = 32'h10; mem[8'h11] = 32'hE0E0_0001;
    mem[8'h12] = 0; mem[8'h13] = 32'h40; mem[8'h14] = pk(0, 0, 0);
    mem[8'h40] = 32'h48; mem[8'h48] = 32'h1; mem[8'h49] = pk(8'h80, 3, 4);
    wr_a = 0; wr_b = 0; writes = 0; txns = 0; nrd = 0;
  endtask

  task automatic run(int cyc);
    int quiet;
    rst_n = 0; sched_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; sched_en = 1;
    repeat (cyc) @(posedge clk);
    @(negedge clk); sched_en = 0;
    repeat (40) @(posedge clk);
    quiet = 1;
    repeat (20) begin @(negedge clk); if (mem_req || txn_req) quiet = 0; end
    chk("R9 idle after enable low", 32'(quiet), 1);
  endtask

  int wd = 0;
  initial begin
    forever begin @(posedge clk); wd++; if (wd > 150000) begin
      failures++; checks++; $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures); $finish;
    end end
  end

  initial begin
    int a_exp, a_ce, h;
    setup();
    repeat (2) @(negedge clk);
    chk("R10 mem_req in reset", 32'(mem_req), 0);
    chk("R10 txn_req in reset", 32'(txn_req), 0);
    // Sweep error counter x leading transaction errors
    for (int ce = 0; ce < 4; ce++) for (int k = 0; k < 4; k++) begin
      setup(); mem[8'h41] = pk(8'h80, ce, 8); kerr = k; bb_at = 99;
      run(700);
      h = (ce != 0 && k >= ce);
      if (h) begin
        chk("R6 halted token", mem[8'h41], pk(8'h48, 0, 8));
        chk("R6 overlay halted", mem[8'h14], pk(8'h48, 0, 8));
        chk("R6 txn count", 32'(txns), 32'(ce));
        chk("R6 B untouched", 32'(wr_b), 0);
      end else begin
        a_ce = (ce == 0) ? 0 : ce - k;
        chk("R4 A sticky token", mem[8'h41], pk(k > 0 ? 8'h08 : 0, a_ce, 0));
        chk("R5 B token", mem[8'h49], pk(0, 3, 0));
        chk("R3 overlay token", mem[8'h14], pk(0, 3, 0));
        chk("R7 overlay cur", mem[8'h12], 32'h48);
        chk("R8 overlay next", mem[8'h13], 32'h1);
        chk("R2 txn count", 32'(txns), 32'(k + 3));
        chk("R5 B single write", 32'(wr_b), 1);
      end
      chk("R4 A single write", 32'(wr_a), 1);
    end
    // Babble at each transaction index
    for (int j = 0; j < 3; j++) begin
      setup(); mem[8'h41] = pk(8'h80, 3, 8); kerr = 0; bb_at = j;
      run(700);
      if (j < 2) begin
        chk("R6 babble A", mem[8'h41], pk(8'h50, 3, 8 - 4 * j));
        chk("R6 babble B untouched", mem[8'h49], pk(8'h80, 3, 4));
      end else begin
        chk("R6 babble after A done", mem[8'h41], pk(0, 3, 0));
        chk("R6 babble B", mem[8'h49], pk(8'h50, 3, 4));
      end
      chk("R6 txns", 32'(txns), 32'(j + 1));
    end
    // Halted overlay
    setup(); mem[8'h14] = pk(8'hC0, 1, 8); kerr = 0; bb_at = 99;
    run(200);
    chk("R6 halted no txn", 32'(txns), 0);
    chk("R6 halted no write", 32'(writes), 0);
    // Terminated next pointer
    setup(); mem[8'h13] = 32'h41; kerr = 0; bb_at = 99;
    run(200);
    chk("R8 no txn", 32'(txns), 0);
    chk("R8 no write", 32'(writes), 0);
    // Two-entry ring read order
    setup(); mem[8'h10] = 32'h20; mem[8'h13] = 32'h1;
    mem[8'h20] = 32'h10; mem[8'h23] = 32'h1;
    run(100);
    for (int i = 0; i < 10; i++)
      chk("R1 R9 read order", 32'(rdlog[i]), 32'((i < 5) ? 16'h10 + i : 16'h20 + i - 5));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule